// File: doc/BRIEF.md
# Host Command Register Handshake

This block is the host-facing register set of a disk controller. A host reaches it over an 8-bit bus with a select, a read strobe, a write strobe and one address line. The bus gives two write-only registers (command and parameter) and two read-only registers (status and result). The host writes one command byte and then as many parameter bytes as that command needs, one at a time. Before it sends the next parameter, it polls status until the parameter-full flag clears.

On the other side, a sequencer port takes each byte. Taking a byte clears the matching full flag. The port receives a one-cycle start pulse once the command has been taken and its last parameter consumed. The sequencer later posts a result byte, which raises the interrupt. Command busy covers the whole command until the host reads the result. The one exception is a seek, which drops busy as soon as it is issued so that further commands can be accepted while the arm moves.

After reset the block refuses command writes for a programmable hold-off period, which defaults to 3 ms at 50 MHz.

Top module: `hcr_regs`

## Requirements
- R1: With `host_addr`=0, a write loads the command register and a read returns status. With `host_addr`=1, a write loads the parameter register and a read returns the result. Read data appears on `host_rdata` one clock after the read strobe and holds until the next read.
- R2: The status byte is laid out as bit0 command busy, bit1 command full, bit2 parameter full, bit3 result full and bit4 interrupt. Bits 7..5 always read 0.
- R3: An accepted command write sets command full and busy and presents the byte on `seq_cmd_code`. `seq_cmd_take` clears command full and leaves busy set.
- R4: A parameter write sets parameter full and presents the byte on `seq_prm_data`. `seq_prm_take` clears the flag. A parameter write while parameter full is set is ignored.
- R5: The parameter count comes from command bits [1:0]. The value 01 needs 1 byte and 10 needs 2 bytes. Any other value needs 3 bytes when `mode_long`=0 and 4 bytes when `mode_long`=1.
- R6: `seq_go` pulses for exactly one cycle, in the clock after the command has been taken and the last required parameter consumed, and never earlier.
- R7: `seq_res_load` stores `seq_res_data` and sets result full and the interrupt bit and line. A host read of the result returns the byte and clears result full, the interrupt and busy. A load in the same cycle as a result read wins.
- R8: For the seek command (code `SEEK_CODE`, default 8'h0C), busy clears in the same clock as its `seq_go`, so a new command write is accepted right after.
- R9: A command write while busy or command full is set is ignored, leaving `seq_cmd_code` unchanged, and sets `cmd_overrun`, which stays set until reset.
- R10: Reset clears all flags, registers and `cmd_overrun`. For `HOLD_CYCLES` clocks after reset `cmd_ready` is low and command writes are ignored. After that `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host register select |
| host_addr | input | 1 | Register address line |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| host_irq | output | 1 | Interrupt line, result waiting |
| mode_long | input | 1 | Default parameter count: 0 gives 3, 1 gives 4 |
| cmd_ready | output | 1 | Hold-off after reset has elapsed |
| cmd_overrun | output | 1 | Sticky: a command write was refused |
| seq_cmd_full | output | 1 | Command byte waiting for the sequencer |
| seq_cmd_code | output | 8 | Command byte |
| seq_cmd_take | input | 1 | Sequencer consumes the command |
| seq_prm_full | output | 1 | Parameter byte waiting |
| seq_prm_data | output | 8 | Parameter byte |
| seq_prm_take | input | 1 | Sequencer consumes the parameter |
| seq_go | output | 1 | One-cycle start of execution |
| seq_res_load | input | 1 | Sequencer posts a result |
| seq_res_data | input | 8 | Result byte |

## Verification
The bench targets the start pulse at the boundary of each parameter count. A lookup or counter that is off by one would fire `seq_go` a byte early or late, and a wrong mode select would treat a four-byte command as three. It writes a second parameter onto a full register and a command onto a busy one: a design that let either through would overwrite the byte the sequencer is about to take. It checks that a seek releases busy at issue time, where a faulty design would refuse the next command. It lands a result load in the same clock as a result read, where wrong priority would lose the new result and its interrupt. It also writes a command during the reset hold-off, which a design that ignored the hold-off would accept.

// File: rtl/hcr_pkg.sv
`timescale 1ns/1ps
package hcr_pkg;
  localparam int HCR_DW  = 8;
  localparam int HCR_PCW = 3;

  typedef struct packed {
    logic [2:0] pad;
    logic       irq;
    logic       res_full;
    logic       prm_full;
    logic       cmd_full;
    logic       busy;
  } hcr_status_t;
endpackage

// File: rtl/hcr_holdoff.sv
`timescale 1ns/1ps
module hcr_holdoff #(
  parameter int HOLD_CYCLES = 150000
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == LIMIT);
endmodule

// File: rtl/hcr_prm_lookup.sv
`timescale 1ns/1ps
module hcr_prm_lookup
  import hcr_pkg::*;
(
  input  logic [1:0]         code_lo,
  input  logic               mode_long,
  output logic [HCR_PCW-1:0] need
);
  always_comb begin
    unique case (code_lo)
      2'b01:   need = HCR_PCW'(1);
      2'b10:   need = HCR_PCW'(2);
      default: need = mode_long ? HCR_PCW'(4) : HCR_PCW'(3);
    endcase
  end
endmodule

// File: rtl/hcr_rd_port.sv
`timescale 1ns/1ps
module hcr_rd_port
  import hcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [HCR_DW-1:0] status,
  input  logic [HCR_DW-1:0] result,
  output logic [HCR_DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= addr ? result : status;
  end
endmodule

// File: rtl/hcr_regs.sv
`timescale 1ns/1ps
module hcr_regs
  import hcr_pkg::*;
#(
  parameter int          HOLD_CYCLES = 150000,
  parameter logic [7:0]  SEEK_CODE   = 8'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [HCR_DW-1:0] host_wdata,
  output logic [HCR_DW-1:0] host_rdata,
  output logic              host_irq,
  input  logic              mode_long,
  output logic              cmd_ready,
  output logic              cmd_overrun,
  output logic              seq_cmd_full,
  output logic [HCR_DW-1:0] seq_cmd_code,
  input  logic              seq_cmd_take,
  output logic              seq_prm_full,
  output logic [HCR_DW-1:0] seq_prm_data,
  input  logic              seq_prm_take,
  output logic              seq_go,
  input  logic              seq_res_load,
  input  logic [HCR_DW-1:0] seq_res_data
);
  logic [HCR_DW-1:0]  cmd_q, prm_q, res_q;
  logic               cmd_full_q, prm_full_q, res_full_q, irq_q, busy_q;
  logic               pend_q, go_q, ovr_q;
  logic [HCR_PCW-1:0] left_q, need;
  hcr_status_t        st;

  logic wr_cmd, wr_prm, rd_any, rd_res, cmd_accept, cmd_reject, go_now;

  hcr_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) i_hold (
    .clk(clk), .rst(rst), .ready(cmd_ready)
  );

  hcr_prm_lookup i_lookup (
    .code_lo(host_wdata[1:0]), .mode_long(mode_long), .need(need)
  );

  assign wr_cmd     = host_sel & host_wr & ~host_addr;
  assign wr_prm     = host_sel & host_wr &  host_addr;
  assign rd_any     = host_sel & host_rd;
  assign rd_res     = rd_any & host_addr;
  // Refusal also covers a command still sitting unread after a seek dropped busy.
  assign cmd_accept = wr_cmd & cmd_ready & ~busy_q & ~cmd_full_q;
  assign cmd_reject = wr_cmd & cmd_ready & (busy_q | cmd_full_q);
  assign go_now     = pend_q & ~cmd_full_q & (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0; prm_q <= '0; res_q <= '0;
      cmd_full_q <= 1'b0; prm_full_q <= 1'b0; res_full_q <= 1'b0;
      irq_q <= 1'b0; busy_q <= 1'b0; pend_q <= 1'b0; go_q <= 1'b0;
      ovr_q <= 1'b0; left_q <= '0;
    end else begin
      // parameter channel
      if (wr_prm && !prm_full_q) begin
        prm_q      <= host_wdata;
        prm_full_q <= 1'b1;
      end else if (seq_prm_take && prm_full_q) begin
        prm_full_q <= 1'b0;
        if (left_q != '0) left_q <= left_q - 1'b1;
      end
      // command channel
      if (seq_cmd_take && cmd_full_q) cmd_full_q <= 1'b0;
      if (cmd_accept) begin
        cmd_q      <= host_wdata;
        cmd_full_q <= 1'b1;
        busy_q     <= 1'b1;
        pend_q     <= 1'b1;
        left_q     <= need;
      end
      if (cmd_reject) ovr_q <= 1'b1;
      // start of execution
      go_q <= go_now;
      if (go_now) begin
        pend_q <= 1'b0;
        if (cmd_q == SEEK_CODE) busy_q <= 1'b0;
      end
      // result channel, load after read so a load wins
      if (rd_res) begin
        res_full_q <= 1'b0;
        irq_q      <= 1'b0;
        busy_q     <= 1'b0;
      end
      if (seq_res_load) begin
        res_q      <= seq_res_data;
        res_full_q <= 1'b1;
        irq_q      <= 1'b1;
      end
    end
  end

  always_comb begin
    st          = '0;
    st.busy     = busy_q;
    st.cmd_full = cmd_full_q;
    st.prm_full = prm_full_q;
    st.res_full = res_full_q;
    st.irq      = irq_q;
  end

  hcr_rd_port i_rd (
    .clk(clk), .rst(rst), .rd_en(rd_any), .addr(host_addr),
    .status(st), .result(res_q), .rdata(host_rdata)
  );

  assign host_irq     = irq_q;
  assign cmd_overrun  = ovr_q;
  assign seq_cmd_full = cmd_full_q;
  assign seq_cmd_code = cmd_q;
  assign seq_prm_full = prm_full_q;
  assign seq_prm_data = prm_q;
  assign seq_go       = go_q;
endmodule

// File: rtl/hcr_regs_chk.sv
`timescale 1ns/1ps
module hcr_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_sel,
  input logic       host_addr,
  input logic       host_rd,
  input logic       host_wr,
  input logic [2:0] rd_pad,
  input logic       host_irq,
  input logic       cmd_ready,
  input logic       cmd_overrun,
  input logic       seq_cmd_full,
  input logic       seq_cmd_take,
  input logic       seq_prm_full,
  input logic       seq_prm_take,
  input logic       seq_go,
  input logic       seq_res_load
);
  assert_status_pad_R2: assert property (@(posedge clk) disable iff (rst)
    (host_sel && host_rd && !host_addr) |=> (rd_pad == 3'b000));

  assert_cmd_take_R3: assert property (@(posedge clk) disable iff (rst)
    (seq_cmd_take && seq_cmd_full) |=> !seq_cmd_full);

  assert_prm_take_R4: assert property (@(posedge clk) disable iff (rst)
    (seq_prm_take && seq_prm_full) |=> !seq_prm_full);

  assert_go_single_R6: assert property (@(posedge clk) disable iff (rst)
    seq_go |=> !seq_go);

  assert_irq_set_R7: assert property (@(posedge clk) disable iff (rst)
    seq_res_load |=> host_irq);

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (host_sel && host_rd && host_addr && !seq_res_load) |=> !host_irq);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_overrun |=> cmd_overrun);

  assert_holdoff_R10: assert property (@(posedge clk) disable iff (rst)
    (host_sel && host_wr && !host_addr && !cmd_ready) |=> !seq_cmd_full);
endmodule

bind hcr_regs hcr_regs_chk i_chk (
  .clk(clk), .rst(rst), .host_sel(host_sel), .host_addr(host_addr),
  .host_rd(host_rd), .host_wr(host_wr), .rd_pad(host_rdata[7:5]),
  .host_irq(host_irq), .cmd_ready(cmd_ready), .cmd_overrun(cmd_overrun),
  .seq_cmd_full(seq_cmd_full), .seq_cmd_take(seq_cmd_take),
  .seq_prm_full(seq_prm_full), .seq_prm_take(seq_prm_take),
  .seq_go(seq_go), .seq_res_load(seq_res_load)
);

// File: tb/test_hcr_regs.sv
`timescale 1ns/1ps
module test_hcr_regs;
  localparam int HOLD = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_sel = 0, host_addr = 0, host_rd = 0, host_wr = 0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_irq, mode_long = 0, cmd_ready, cmd_overrun;
  logic       seq_cmd_full, seq_cmd_take = 0, seq_prm_full, seq_prm_take = 0;
  logic [7:0] seq_cmd_code, seq_prm_data, seq_res_data = '0;
  logic       seq_go, seq_res_load = 0;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  hcr_regs #(.HOLD_CYCLES(HOLD), .SEEK_CODE(8'h0C)) i_hcr_regs (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset;
    rst = 1'b1; step(2); rst = 1'b0;
    step(HOLD + 2);
  endtask

  task automatic hwrite(input logic a, input logic [7:0] d);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    step(1);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic hread(input logic a, output logic [7:0] d);
    host_sel = 1; host_rd = 1; host_addr = a;
    step(1);
    host_sel = 0; host_rd = 0;
    d = host_rdata;
  endtask

  task automatic take_cmd;
    seq_cmd_take = 1; step(1); seq_cmd_take = 0;
  endtask

  task automatic take_prm;
    seq_prm_take = 1; step(1); seq_prm_take = 0;
  endtask

  task automatic post_result(input logic [7:0] d);
    seq_res_load = 1; seq_res_data = d; step(1); seq_res_load = 0;
  endtask

  // reset state and hold-off (R10, R2)
  task automatic t_reset;
    logic [7:0] d;
    rst = 1'b1; step(2); rst = 1'b0;
    chk("R10 ready low after reset", cmd_ready, 0);
    hwrite(0, 8'h01);
    chk("R10 cmd ignored in hold-off", seq_cmd_full, 0);
    hread(0, d);
    chk("R10 status zero in hold-off", d, 8'h00);
    step(HOLD);
    chk("R10 ready after hold-off", cmd_ready, 1);
    chk("R10 irq clear", host_irq, 0);
    chk("R10 overrun clear", cmd_overrun, 0);
  endtask

  // single parameter command path (R1 R3 R4 R5 R6)
  task automatic t_one_param;
    logic [7:0] d;
    do_reset();
    hwrite(0, 8'h41);
    chk("R3 code shown", seq_cmd_code, 8'h41);
    hread(0, d);
    chk("R1 R2 status busy+cmd full", d, 8'h03);
    chk("R1 rdata holds", host_rdata, 8'h03);
    take_cmd();
    hread(0, d);
    chk("R3 take clears full, busy stays", d, 8'h01);
    hwrite(1, 8'h5A);
    chk("R4 parameter data", seq_prm_data, 8'h5A);
    hread(0, d);
    chk("R2 status prm full", d, 8'h05);
    take_prm();
    chk("R6 no go at take edge", seq_go, 0);
    step(1);
    chk("R5 R6 go after one param", seq_go, 1);
    step(1);
    chk("R6 go is one cycle", seq_go, 0);
  endtask

  // result posting and read (R7, R1)
  task automatic t_result;
    logic [7:0] d;
    t_one_param();
    post_result(8'hA5);
    chk("R7 irq line", host_irq, 1);
    hread(0, d);
    chk("R7 R2 status res+irq+busy", d, 8'h19);
    hread(1, d);
    chk("R1 R7 result byte", d, 8'hA5);
    chk("R7 irq cleared", host_irq, 0);
    hread(0, d);
    chk("R7 status idle after read", d, 8'h00);
  endtask

  // parameter write while full is ignored (R4)
  task automatic t_prm_full;
    do_reset();
    hwrite(0, 8'h02);
    take_cmd();
    hwrite(1, 8'h11);
    hwrite(1, 8'h22);
    chk("R4 second write ignored", seq_prm_data, 8'h11);
    take_prm();
    chk("R4 take clears", seq_prm_full, 0);
    hwrite(1, 8'h33);
    chk("R4 next byte accepted", seq_prm_data, 8'h33);
    take_prm();
    step(1);
    chk("R5 go after two params", seq_go, 1);
  endtask

  // default counts by mode (R5, R6)
  task automatic t_count(input logic m, input int n);
    int early = 0;
    do_reset();
    mode_long = m;
    hwrite(0, 8'h00);
    mode_long = 0;
    take_cmd();
    for (int k = 0; k < n; k++) begin
      hwrite(1, 8'(k));
      take_prm();
      if (k < n - 1) begin
        step(1);
        if (seq_go) early++;
      end
    end
    chk("R6 no early go", early, 0);
    step(1);
    chk(m ? "R5 go after 4 params" : "R5 go after 3 params", seq_go, 1);
  endtask

  // seek drops busy early (R8)
  task automatic t_seek;
    logic [7:0] d;
    do_reset();
    hwrite(0, 8'h0C);
    take_cmd();
    for (int k = 0; k < 3; k++) begin hwrite(1, 8'h70); take_prm(); end
    step(1);
    chk("R8 seek go", seq_go, 1);
    hread(0, d);
    chk("R8 busy clear after seek issue", d, 8'h00);
    hwrite(0, 8'h01);
    chk("R8 next command accepted", seq_cmd_code, 8'h01);
    chk("R8 no overrun", cmd_overrun, 0);
  endtask

  // command while busy (R9)
  task automatic t_overrun;
    do_reset();
    hwrite(0, 8'h01);
    hwrite(0, 8'h55);
    chk("R9 code unchanged", seq_cmd_code, 8'h01);
    chk("R9 overrun set", cmd_overrun, 1);
    take_cmd();
    step(3);
    chk("R9 overrun sticky", cmd_overrun, 1);
    rst = 1'b1; step(1); rst = 1'b0;
    chk("R10 reset clears overrun", cmd_overrun, 0);
    chk("R10 reset clears cmd full", seq_cmd_full, 0);
  endtask

  // load and read in one cycle (R7)
  task automatic t_collide;
    logic [7:0] d;
    do_reset();
    post_result(8'h81);
    host_sel = 1; host_rd = 1; host_addr = 1;
    seq_res_load = 1; seq_res_data = 8'h3C;
    step(1);
    host_sel = 0; host_rd = 0; seq_res_load = 0;
    chk("R7 collide returns old", host_rdata, 8'h81);
    chk("R7 load wins irq", host_irq, 1);
    hread(1, d);
    chk("R7 new result kept", d, 8'h3C);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_result();
    t_prm_full();
    t_count(0, 3);
    t_count(1, 4);
    t_seek();
    t_overrun();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule